// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether a received Ethernet frame is kept. It watches the first six bytes of the frame, which carry the destination address, as they arrive from the MAC one byte per valid cycle. While the bytes stream in, it runs three checks. It compares them against a programmed station address. It checks whether every bit is one, which is the broadcast address. It also accumulates the Ethernet CRC-32 of the address, so that six bits of that CRC can index a 64-bit multicast hash table.

A mode byte selects which address classes are taken: broadcast, hashed multicast, and promiscuous reception of any individual address. A monitor mode lets the frame be judged as normal while telling the buffer logic not to store it.

Two cycles after the sixth byte is sampled, the block gives a one-cycle verdict. The verdict has three parts: an accept flag, a class flag (individual or group address), and a store enable for the frame buffer. The verdict arrives at a fixed point, well before the payload is committed.

Top module: `rxaddr_filter`

## Requirements
- R1: While reset is high, and in the cycle after it, `decision_valid`, `accept`, `group_flag` and `store_en` are all 0.
- R2: `decision_valid` is high for exactly one cycle. It rises in the second cycle after the clock edge that samples the sixth address byte, and no earlier.
- R3: An individual address is one whose first byte has bit 0 clear. If it equals `station_addr` (byte k of the frame compared with `station_addr[8k+7:8k]`), it is accepted with `group_flag` 0.
- R4: An individual address that differs from `station_addr` is rejected, unless `rx_mode` bit 4 (promiscuous) is set, in which case it is accepted.
- R5: An address of six 0xFF bytes is broadcast. It is accepted exactly when `rx_mode` bit 2 is set, and it reports `group_flag` 1.
- R6: A group address is one whose first byte has bit 0 set and which is not broadcast. It is accepted exactly when `rx_mode` bit 3 is set and `hash_table[h]` is 1. Bit i of `hash_table` is bit i mod 8 of table byte i/8. To form h, take the reflected CRC-32 (polynomial 0xEDB88320, preset all ones, data taken LSB first, no final inversion) over the six address bytes. Then h bit 5 is CRC bit 0, h bit 4 is CRC bit 1, and so on down to h bit 0, which is CRC bit 5.
- R7: With `hash_table` all ones and `rx_mode` bit 3 set, every group address is accepted. With bit 3 clear, no group address is accepted, whatever the table holds.
- R8: When `rx_mode` bit 5 (monitor) is set, `store_en` is 0 and `accept` still reports the verdict. When bit 5 is clear, `store_en` equals `accept`. `store_en` is never 1 without `accept`.
- R9: Valid bytes after the sixth are ignored until the next `sof`. A `sof` in the middle of an address restarts the capture, and the verdict follows the new address.
- R10: Whenever `decision_valid` is 0, `accept`, `group_flag` and `store_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A received byte is present on `byte_data` |
| sof | input | 1 | Marks the first byte of a frame; sampled only together with `byte_valid` |
| byte_data | input | 8 | Received byte, in wire order |
| rx_mode | input | 8 | Bit 2 broadcast, bit 3 multicast, bit 4 promiscuous, bit 5 monitor; other bits unused |
| station_addr | input | 48 | Station address; byte k of the frame is bits [8k+7:8k] |
| hash_table | input | 64 | Multicast hash table; bit i is table byte i/8, bit i mod 8 |
| decision_valid | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Frame address is accepted |
| group_flag | output | 1 | 1 for group (multicast or broadcast) address, 0 for individual |
| store_en | output | 1 | Frame may be written to the buffer |

## Verification
The assertions assume three things about the inputs. First, `rx_mode` is steady in the cycle the verdict is formed. Second, a new frame's six address bytes take at least two cycles before another verdict can be due, so a verdict strobe cannot repeat on consecutive cycles. Third, `sof` only means something together with `byte_valid`. The stimulus keeps within these rules in the same way throughout. It changes the mode, station address and table only while no address is in flight. It drives bytes on falling edges. After every address it leaves at least one idle cycle before the next `sof`.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int MAC_BYTES      = 6;
    localparam int CRC_W          = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_PRESET    = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        CLASS_INDIVIDUAL = 2'd0,
        CLASS_GROUP      = 2'd1,
        CLASS_BROADCAST  = 2'd2
    } addr_class_e;

    typedef struct packed {
        logic take_bcast;
        logic take_mcast;
        logic promisc;
        logic monitor;
    } rx_mode_t;

    typedef struct packed {
        logic station_hit;
        logic all_ones;
        logic group_bit;
    } match_t;

    function automatic rx_mode_t decode_mode(input logic [5:2] m);
        rx_mode_t r;
        r.take_bcast = m[2];
        r.take_mcast = m[3];
        r.promisc    = m[4];
        r.monitor    = m[5];
        return r;
    endfunction

    // Reflected CRC-32 over one byte, LSB first, mask formulation.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [7:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            r = (r >> 1) ^ ({CRC_W{r[0] ^ d[b]}} & CRC_POLY_REFL);
        end
        return r;
    endfunction

    function automatic addr_class_e classify(input match_t m);
        if (!m.group_bit)     return CLASS_INDIVIDUAL;
        else if (m.all_ones)  return CLASS_BROADCAST;
        else                  return CLASS_GROUP;
    endfunction

endpackage

// File: rtl/rxf_byte_seq.sv
module rxf_byte_seq #(
    parameter int ADDR_BYTES = 6,
    localparam int CW = $clog2(ADDR_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_valid,
    input  logic          sof,
    output logic          take,
    output logic          first,
    output logic          last,
    output logic [CW-1:0] idx
);
    localparam logic [CW-1:0] IDLE_CNT = CW'(ADDR_BYTES);
    localparam logic [CW-1:0] LAST_IDX = CW'(ADDR_BYTES - 1);

    logic [CW-1:0] cnt_q;

    always_comb begin
        first = byte_valid && sof;
        take  = first || (byte_valid && (cnt_q < IDLE_CNT));
        idx   = first ? '0 : cnt_q;
        last  = take && (idx == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= IDLE_CNT;
        end else if (take) begin
            cnt_q <= idx + CW'(1);
        end
    end

endmodule

// File: rtl/rxf_crc.sv
module rxf_crc
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 take,
    input  logic                 first,
    input  logic [7:0]           data,
    output logic [HASH_BITS-1:0] hash_idx
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_base;

    assign crc_base = first ? CRC_PRESET : crc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_PRESET;
        end else if (take) begin
            crc_q <= crc_step(crc_base, data);
        end
    end

    // The table index is the low CRC bits in reversed order.
    for (genvar g = 0; g < HASH_BITS; g++) begin : g_rev
        assign hash_idx[g] = crc_q[HASH_BITS-1-g];
    end

    logic unused_crc_hi;
    assign unused_crc_hi = ^crc_q[CRC_W-1:HASH_BITS];

endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int CW = $clog2(ADDR_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    take,
    input  logic                    first,
    input  logic [CW-1:0]           idx,
    input  logic [7:0]              data,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output match_t                  match
);
    logic [7:0] stn_byte;
    match_t     m_q;
    match_t     m_next;

    always_comb begin
        stn_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (idx == CW'(k)) stn_byte = station_addr[8*k +: 8];
        end
    end

    always_comb begin
        m_next = m_q;
        if (first) begin
            m_next.station_hit = (data == stn_byte);
            m_next.all_ones    = (data == 8'hFF);
            m_next.group_bit   = data[0];
        end else begin
            m_next.station_hit = m_q.station_hit && (data == stn_byte);
            m_next.all_ones    = m_q.all_ones && (data == 8'hFF);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '0;
        end else if (take) begin
            m_q <= m_next;
        end
    end

    assign match = m_q;

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 6,
    localparam int TABLE_BITS = 1 << HASH_BITS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  eval,
    input  match_t                match,
    input  logic [HASH_BITS-1:0]  hash_idx,
    input  logic [TABLE_BITS-1:0] hash_table,
    input  rx_mode_t              mode,
    output logic                  decision_valid,
    output logic                  accept,
    output logic                  group_flag,
    output logic                  store_en
);
    addr_class_e cls;
    logic        hit;

    always_comb begin
        cls = classify(match);
        unique case (cls)
            CLASS_INDIVIDUAL: hit = match.station_hit || mode.promisc;
            CLASS_BROADCAST:  hit = mode.take_bcast;
            CLASS_GROUP:      hit = mode.take_mcast && hash_table[hash_idx];
            default:          hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            decision_valid <= 1'b0;
            accept         <= 1'b0;
            group_flag     <= 1'b0;
            store_en       <= 1'b0;
        end else begin
            decision_valid <= eval;
            accept         <= eval && hit;
            group_flag     <= eval && (cls != CLASS_INDIVIDUAL);
            store_en       <= eval && hit && !mode.monitor;
        end
    end

endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = MAC_BYTES,
    parameter int HASH_BITS  = 6,
    localparam int CW         = $clog2(ADDR_BYTES + 1),
    localparam int TABLE_BITS = 1 << HASH_BITS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    byte_valid,
    input  logic                    sof,
    input  logic [7:0]              byte_data,
    input  logic [7:0]              rx_mode,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic [TABLE_BITS-1:0]   hash_table,
    output logic                    decision_valid,
    output logic                    accept,
    output logic                    group_flag,
    output logic                    store_en
);
    logic                 take;
    logic                 first;
    logic                 last;
    logic [CW-1:0]        idx;
    logic [HASH_BITS-1:0] hash_idx;
    match_t               match;
    rx_mode_t             mode;
    logic                 addr_done_q;

    assign mode = decode_mode(rx_mode[5:2]);

    logic unused_mode_bits;
    assign unused_mode_bits = ^{rx_mode[7:6], rx_mode[1:0]};

    rxf_byte_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .sof(sof),
        .take(take), .first(first), .last(last), .idx(idx)
    );

    rxf_crc #(.HASH_BITS(HASH_BITS)) u_crc (
        .clk(clk), .rst(rst), .take(take), .first(first),
        .data(byte_data), .hash_idx(hash_idx)
    );

    rxf_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
        .clk(clk), .rst(rst), .take(take), .first(first), .idx(idx),
        .data(byte_data), .station_addr(station_addr), .match(match)
    );

    always_ff @(posedge clk) begin
        if (rst) addr_done_q <= 1'b0;
        else     addr_done_q <= last;
    end

    rxf_decide #(.HASH_BITS(HASH_BITS)) u_decide (
        .clk(clk), .rst(rst), .eval(addr_done_q), .match(match),
        .hash_idx(hash_idx), .hash_table(hash_table), .mode(mode),
        .decision_valid(decision_valid), .accept(accept),
        .group_flag(group_flag), .store_en(store_en)
    );

endmodule

// File: rtl/rxaddr_filter_chk.sv
module rxaddr_filter_chk (
    input logic clk,
    input logic rst,
    input logic byte_valid,
    input logic mode_monitor,
    input logic decision_valid,
    input logic accept,
    input logic group_flag,
    input logic store_en
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!decision_valid && !accept && !group_flag && !store_en));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        decision_valid |-> $past(byte_valid, 2));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        decision_valid |=> !decision_valid);

    assert_monitor_no_store_R8: assert property (@(posedge clk) disable iff (rst)
        (decision_valid && $past(mode_monitor)) |-> !store_en);

    assert_store_needs_accept_R8: assert property (@(posedge clk) disable iff (rst)
        store_en |-> accept);

    assert_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
        !decision_valid |-> (!accept && !group_flag && !store_en));

endmodule

bind rxaddr_filter rxaddr_filter_chk u_chk (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .mode_monitor(rx_mode[5]),
    .decision_valid(decision_valid), .accept(accept),
    .group_flag(group_flag), .store_en(store_en)
);

// File: tb/rxaddr_filter_tb.sv
module rxaddr_filter_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        byte_valid;
    logic        sof;
    logic [7:0]  byte_data;
    logic [7:0]  rx_mode;
    logic [47:0] station_addr;
    logic [63:0] hash_table;
    logic        decision_valid, accept, group_flag, store_en;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] M_BCAST = 8'h04;
    localparam logic [7:0] M_MCAST = 8'h08;
    localparam logic [7:0] M_PROM  = 8'h10;
    localparam logic [7:0] M_MON   = 8'h20;

    localparam logic [47:0] STN   = 48'h5A_34_12_EF_CD_02;  // first byte 0x02
    localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

    always #5 clk = ~clk;

    rxaddr_filter u_dut (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .sof(sof),
        .byte_data(byte_data), .rx_mode(rx_mode), .station_addr(station_addr),
        .hash_table(hash_table), .decision_valid(decision_valid),
        .accept(accept), .group_flag(group_flag), .store_en(store_en)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] hash_of(input logic [47:0] a);
        logic [31:0] c;
        logic [7:0]  d;
        c = 32'hFFFFFFFF;
        for (int k = 0; k < 6; k++) begin
            d = a[8*k +: 8];
            for (int b = 0; b < 8; b++) begin
                if ((c[0] ^ d[b]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
                else                       c = c >> 1;
            end
        end
        return {c[0], c[1], c[2], c[3], c[4], c[5]};
    endfunction

    task automatic drive_bytes(input logic [47:0] a, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            byte_valid = 1'b1;
            sof        = (k == 0);
            byte_data  = a[8*k +: 8];
        end
    endtask

    // Sends a full address and checks the verdict timing and values.
    task automatic run_addr(input string req, input logic [47:0] a,
                            input logic exp_acc, input logic exp_grp,
                            input logic exp_store);
        drive_bytes(a, 6);
        @(negedge clk);                        // sixth byte sampled
        byte_valid = 1'b0; sof = 1'b0;
        check("R2", "valid one cycle after last byte", decision_valid, 0);
        @(negedge clk);
        check("R2", "valid in second cycle", decision_valid, 1);
        check(req, "accept", accept, exp_acc);
        check(req, "group_flag", group_flag, exp_grp);
        check(req, "store_en", store_en, exp_store);
        @(negedge clk);
        check("R2", "valid drops after one cycle", decision_valid, 0);
        check("R10", "accept low when idle", accept, 0);
        check("R10", "store low when idle", store_en, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; byte_valid = 1'b0; sof = 1'b0; byte_data = '0;
        rx_mode = '0; station_addr = STN; hash_table = '0;
        repeat (3) @(negedge clk);
        check("R1", "valid in reset", decision_valid, 0);
        check("R1", "accept in reset", accept, 0);
        check("R1", "store in reset", store_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "group after reset", group_flag, 0);
    endtask

    task automatic t_unicast();
        rx_mode = M_BCAST;
        run_addr("R3", STN, 1, 0, 1);
        run_addr("R4", STN ^ 48'h0100_0000_0000, 0, 0, 0);
        run_addr("R4", 48'h0, 0, 0, 0);
        rx_mode = M_PROM;
        run_addr("R4", STN ^ 48'h0100_0000_0000, 1, 0, 1);
    endtask

    task automatic t_broadcast();
        rx_mode = M_BCAST;
        run_addr("R5", BCAST, 1, 1, 1);
        rx_mode = M_MCAST | M_PROM;
        hash_table = '1;
        run_addr("R5", BCAST, 0, 1, 0);
        hash_table = '0;
    endtask

    task automatic t_multicast();
        logic [47:0] g1, g2;
        logic [5:0]  h1;
        g1 = 48'h01_00_5E_00_00_01;
        g2 = 48'h77_66_55_44_33_03;
        h1 = hash_of(g1);
        rx_mode = M_MCAST;
        hash_table = 64'h1 << h1;
        run_addr("R6", g1, 1, 1, 1);
        hash_table = ~(64'h1 << h1);
        run_addr("R6", g1, 0, 1, 0);
        hash_table = '1;
        run_addr("R7", g1, 1, 1, 1);
        run_addr("R7", g2, 1, 1, 1);
        rx_mode = M_BCAST | M_PROM;
        run_addr("R7", g2, 0, 1, 0);
        hash_table = '0;
    endtask

    task automatic t_monitor();
        rx_mode = M_MON | M_BCAST;
        run_addr("R8", STN, 1, 0, 0);
        run_addr("R8", BCAST, 1, 1, 0);
        rx_mode = M_BCAST;
        run_addr("R8", BCAST, 1, 1, 1);
    endtask

    task automatic t_sequence();
        int extra_valid;
        rx_mode = M_BCAST;
        drive_bytes(STN, 6);
        extra_valid = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            byte_valid = 1'b1; sof = 1'b0; byte_data = 8'hFF;
            if (decision_valid) extra_valid++;
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            byte_valid = 1'b0;
            if (decision_valid) extra_valid++;
        end
        check("R9", "one verdict despite trailing bytes", extra_valid, 1);
        // Partial station address, then restart with broadcast.
        drive_bytes(STN, 3);
        run_addr("R9", BCAST, 1, 1, 1);
    endtask

    initial begin
        t_reset();
        t_unicast();
        t_broadcast();
        t_multicast();
        t_monitor();
        t_sequence();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule